// File: doc/BRIEF.md
# Latched-Address Active-Low Decoder

This block turns a 4-bit address into a 16-line selection with active-low outputs. The address first passes through a holding register. While the load-enable input is high, the register takes a new address on every clock edge. While it is low, the register keeps the last address it took, and later changes on the address pins have no effect. This is the clocked form of a transparent latch, so it fits FPGA fabric.

A separate active-low enable gates the decoded outputs. With the enable low, only the output picked by the held address is driven low. With the enable high, every output is high. The enable never touches the held address.

The same structure works as a 1-to-16 demultiplexer. The enable pin carries a serial data bit, and the held address steers that bit to one output line. All other lines stay high. The outputs are registered.

Top module: `latched_decoder`

## Requirements
- R1: A synchronous active-high reset clears the held address to 0 and sets all sixteen outputs high. The first edge after reset with `en_n` low drives `dec_n` to 16'hFFFE.
- R2: On each clock edge where `load_en` is 1, the held address takes the value on `addr`. `addr[0]` is the least significant bit. The outputs show this address one edge later.
- R3: On a clock edge where `load_en` is 0, the held address does not change, and `dec_n` does not change for any value on `addr`.
- R4: On an edge where `en_n` is 0, `dec_n` becomes all ones except bit k, which is 0, where k is the held address. Bit i of `dec_n` is output line i.
- R5: On an edge where `en_n` is 1, `dec_n` becomes 16'hFFFF, whatever the held address is.
- R6: `en_n` has no effect on the held address. An address loaded or kept while the outputs are disabled is the one that appears once `en_n` returns low.
- R7: As a demultiplexer, the selected output takes the value `en_n` had at the previous edge, and every unselected output stays 1.
- R8: At most one bit of `dec_n` is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | When 1, the held address loads from `addr` at each edge |
| addr | input | 4 | Binary address, bit 0 least significant |
| en_n | input | 1 | Active-low output enable, also the data input in demultiplexer use |
| dec_n | output | 16 | Registered active-low decoded outputs, bit i is line i |

## Verification
A change on `en_n` reaches `dec_n` after one clock edge, because only the output register lies in its path. A change on `addr` with `load_en` high needs two edges: one into the held-address register and one into the output register. The bench drives every input shortly after a rising edge. It then waits exactly one edge (enable and demultiplexer checks) or two edges (address sweep, hold and reload checks) and samples a few nanoseconds after that edge. Hold checks change `addr` on every cycle and compare `dec_n` after each edge.

// File: rtl/latdec_pkg.sv
package latdec_pkg;
  localparam int unsigned LATDEC_ADDR_W = 4;
  localparam int unsigned LATDEC_LINES  = 1 << LATDEC_ADDR_W;
endpackage

// File: rtl/latdec_addr_hold.sv
module latdec_addr_hold #(
  parameter int unsigned ADDR_W = latdec_pkg::LATDEC_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_held
);
  // Clocked stand-in for a transparent latch: loads while load_en is high.
  always_ff @(posedge clk) begin
    if (rst)          addr_held <= '0;
    else if (load_en) addr_held <= addr_in;
  end
endmodule

// File: rtl/latdec_onehot.sv
module latdec_onehot #(
  parameter int unsigned ADDR_W = latdec_pkg::LATDEC_ADDR_W,
  localparam int unsigned LINES = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] sel,
  output logic [LINES-1:0]  hot
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign hot[i] = (sel == ADDR_W'(i));
  end
endmodule

// File: rtl/latdec_out_gate.sv
module latdec_out_gate #(
  parameter int unsigned LINES = latdec_pkg::LATDEC_LINES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_n,
  input  logic [LINES-1:0] hot,
  output logic [LINES-1:0] out_n
);
  // Registered, active-low; disabled forces every line high.
  always_ff @(posedge clk) begin
    if (rst)       out_n <= '1;
    else if (en_n) out_n <= '1;
    else           out_n <= ~hot;
  end
endmodule

// File: rtl/latched_decoder.sv
module latched_decoder #(
  parameter int unsigned ADDR_W = latdec_pkg::LATDEC_ADDR_W,
  localparam int unsigned LINES = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_n,
  output logic [LINES-1:0]  dec_n
);
  logic [ADDR_W-1:0] held_addr;
  logic [LINES-1:0]  line_hot;

  latdec_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .addr_in   (addr),
    .addr_held (held_addr)
  );

  latdec_onehot #(.ADDR_W(ADDR_W)) u_dec (
    .sel (held_addr),
    .hot (line_hot)
  );

  latdec_out_gate #(.LINES(LINES)) u_gate (
    .clk   (clk),
    .rst   (rst),
    .en_n  (en_n),
    .hot   (line_hot),
    .out_n (dec_n)
  );
endmodule

// File: rtl/latched_decoder_chk.sv
module latched_decoder_chk #(
  parameter int unsigned ADDR_W = latdec_pkg::LATDEC_ADDR_W,
  localparam int unsigned LINES = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              load_en,
  input logic [ADDR_W-1:0] addr,
  input logic              en_n,
  input logic [LINES-1:0]  dec_n,
  input logic [ADDR_W-1:0] held
);
  AST_RESET_ALL_HIGH: assert property (@(posedge clk) rst |=> (dec_n == '1)); // R1
  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (held == $past(addr))); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(held)); // R3
  AST_SELECT_LINE: assert property (@(posedge clk) disable iff (rst)
    !en_n |=> (dec_n == ~(LINES'(1) << $past(held)))); // R4
  AST_DISABLED_HIGH: assert property (@(posedge clk) disable iff (rst)
    en_n |=> (dec_n == '1)); // R5
  AST_MUTEX_LOW: assert property (@(posedge clk) disable iff (rst)
    $countones(~dec_n) <= 1); // R8
endmodule

bind latched_decoder latched_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .load_en (load_en),
  .addr    (addr),
  .en_n    (en_n),
  .dec_n   (dec_n),
  .held    (held_addr)
);

// File: tb/tb_latched_decoder.sv
module tb_latched_decoder;
  localparam int unsigned AW = 4;
  localparam int unsigned NL = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          en_n = 1'b1;
  logic [NL-1:0] dec_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  latched_decoder #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .load_en(load_en), .addr(addr), .en_n(en_n), .dec_n(dec_n)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [NL-1:0] sel_pat(input int k);
    return ~(NL'(1) << k);
  endfunction

  task automatic check(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: dec_n=%h expected %h", req, act, exp);
    end
  endtask

  task automatic check_mutex();
    n_checks++;
    if ($countones(~dec_n) > 1) begin
      n_fail++;
      $display("FAIL R8: dec_n=%h has %0d low lines, expected at most 1", dec_n, $countones(~dec_n));
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    // R1: reset state
    tick(); tick(); tick();
    check("R1 reset outputs", dec_n, '1);
    rst = 1'b0; en_n = 1'b0;
    tick();
    check("R1 held cleared to 0", dec_n, 16'hFFFE);

    // R2/R4: transparent sweep of all addresses
    load_en = 1'b1;
    for (int a = 0; a < NL; a++) begin
      addr = AW'(a);
      tick(); tick();
      check($sformatf("R2 R4 sweep addr %0d", a), dec_n, sel_pat(a));
      check_mutex();
    end

    // R3: hold while addr moves
    addr = 4'd5; tick();
    load_en = 1'b0;
    tick(); tick();
    check("R3 held 5", dec_n, sel_pat(5));
    for (int a = 0; a < NL; a++) begin
      addr = AW'(15 - a);
      tick();
      check($sformatf("R3 hold with addr %0d", 15 - a), dec_n, sel_pat(5));
    end

    // R5: disabled, all high regardless of address
    en_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      addr = AW'(a * 3);
      tick();
      check("R5 disabled", dec_n, '1);
    end
    // R6: held address survives the enable toggle
    en_n = 1'b0; tick();
    check("R6 held survives disable", dec_n, sel_pat(5));
    // R6: load while disabled
    en_n = 1'b1; load_en = 1'b1; addr = 4'd9; tick();
    load_en = 1'b0; addr = 4'd2; tick();
    check("R5 disabled during load", dec_n, '1);
    en_n = 1'b0; tick();
    check("R6 loaded while disabled", dec_n, sel_pat(9));

    // R7: demultiplexer on several addresses
    foreach (pat[i]) pat[i] = 1'b0;
    pat = 16'b1011_0010_1100_0101;
    for (int s = 0; s < 3; s++) begin
      int k;
      k = (s == 0) ? 9 : ((s == 1) ? 0 : 15);
      en_n = 1'b1; load_en = 1'b1; addr = AW'(k); tick();
      load_en = 1'b0; tick();
      for (int i = 0; i < 16; i++) begin
        en_n = pat[i];
        tick();
        check($sformatf("R7 demux line %0d bit %0d", k, i), dec_n,
              pat[i] ? 16'hFFFF : sel_pat(k));
        check_mutex();
      end
    end

    // R1: reset mid-run
    en_n = 1'b0; load_en = 1'b1; addr = 4'd12; tick(); tick();
    check("R2 pre-reset load 12", dec_n, sel_pat(12));
    rst = 1'b1; load_en = 1'b0; tick();
    check("R1 mid-run reset outputs", dec_n, '1);
    rst = 1'b0; tick();
    check("R1 mid-run held cleared", dec_n, 16'hFFFE);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule